// File: doc/BRIEF.md
# Serial PRBS and Pattern Sync Monitor

This block watches a received serial bit stream and decides whether it carries the pseudo-random sequence or fixed repeating word that software selected. A four-bit selector, a polarity flag and a load strobe pick one of eight linear-feedback sequences or one of eight eight-bit words. The block then finds the phase of that stream by itself. While hunting in a sequence mode it feeds the received bits straight into its local shift register. In a word mode it slips its word phase by one bit after each mismatch.

Once enough consecutive bits agree, the monitor declares lock. From then on it keeps a record of which of the last 128 bits were wrong. Too many recent errors drop the lock and produce a single-clock loss pulse. Each error also leaves the record 128 bits after it entered, and at that point it appears as a bit-error pulse, provided lock still holds. A burst that breaks lock is therefore never reported as individual bit errors. Only clocks with the enable high advance the block. The bit-slip output exists at the edge but is held low.

Top module: `prbs_rx_mon`

## Requirements
- R1: Synchronous active-high reset clears lock and every pulse output, and selects sequence code 0 with no inversion.
- R2: Selector codes 0 to 7 choose sequences with feedback taps (5,9), (9,11), (14,15), (17,20), (3,20), (18,23), (27,29), (28,31). Each new bit is the XOR of the two tapped earlier bits, counted back from the newest. Code 4 also forces a 1 whenever the 14 preceding bits were all 0. A conforming stream reaches lock from any phase.
- R3: Selector codes 8 to 15 choose repeating words, sent most significant bit first: 00000000, 11111111, 01010101, 00110011, 01111111, 10000000, 01110111, 10001000. A conforming stream reaches lock from any starting phase.
- R4: In sequence mode, lock rises on the bit that completes a run of twice the longest tap count of consecutive matching bits, and never sooner after a load.
- R5: In word mode, lock rises on exactly the 20th consecutive matching bit after a load.
- R6: The polarity flag complements the expected sequence in codes 0 to 7 and has no effect in codes 8 to 15. A sequence of the wrong polarity never locks.
- R7: While locked, lock falls and the loss output pulses for exactly one clock on the bit that makes more than 25 of the last 128 bits wrong. Exactly 25 keeps lock.
- R8: Errors more than 128 enabled bits old no longer count toward loss.
- R9: An error received while locked produces a one-clock bit-error pulse after exactly 128 further enabled clocks, and only while lock is still held.
- R10: Errors inside the window that caused a loss never appear on the bit-error output.
- R11: While locked in sequence mode, the local register runs freely, so one flipped bit yields exactly one bit-error report.
- R12: Selector and polarity are taken only on an enabled clock with the load strobe high. A load clears lock, the error record and the pending reports, and gives no loss pulse.
- R13: With enable low, no state advances and no pulse is produced, whatever the other inputs do.
- R14: The bit-slip output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bit enable; one received bit per enabled clock |
| rx_bit | input | 1 | Received serial bit |
| cfg_set | input | 1 | Load strobe for selector and polarity |
| cfg_sel | input | 4 | Sequence or word selector |
| cfg_inv | input | 1 | Sequence polarity flag |
| sync_o | output | 1 | Lock level |
| loss_o | output | 1 | One-clock pulse when lock is lost |
| err_o | output | 1 | Delayed one-clock bit-error pulse |
| slip_o | output | 1 | Bit-slip indication, tied to 0 |

## Verification
The hardest case to reach from the ports is an error burst that breaks lock and is then never reported as bit errors. To reach it, the stimulus first acquires lock on a fixed word. It then drives 25 wrong bits to show that lock survives at the limit, and one more to break it. It then keeps sending good bits for well over 128 clocks, so the monitor locks again and any stale record would have reached the bit-error output. A single flipped bit in sequence mode, counted at the output 128 clocks later, shows both the exact reporting delay and that the local register runs freely once locked.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;

    localparam int SEL_W  = 4;
    localparam int LFSR_W = 31;
    localparam int PAT_W  = 8;
    localparam int PH_W   = $clog2(PAT_W);
    localparam int CNT_W  = 6;
    localparam int ZRUN   = 14;
    localparam logic [SEL_W-1:0] ZSUP_SEL = 4'd4;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             inv;
    } rx_cfg_t;

    typedef struct packed {
        logic [4:0] tap_lo;
        logic [4:0] tap_hi;
    } taps_t;

    function automatic taps_t poly_taps(input logic [2:0] idx);
        taps_t t;
        case (idx)
            3'd0:    t = '{tap_lo: 5'd5,  tap_hi: 5'd9};
            3'd1:    t = '{tap_lo: 5'd9,  tap_hi: 5'd11};
            3'd2:    t = '{tap_lo: 5'd14, tap_hi: 5'd15};
            3'd3:    t = '{tap_lo: 5'd17, tap_hi: 5'd20};
            3'd4:    t = '{tap_lo: 5'd3,  tap_hi: 5'd20};
            3'd5:    t = '{tap_lo: 5'd18, tap_hi: 5'd23};
            3'd6:    t = '{tap_lo: 5'd27, tap_hi: 5'd29};
            default: t = '{tap_lo: 5'd28, tap_hi: 5'd31};
        endcase
        return t;
    endfunction

    function automatic logic [PAT_W-1:0] pat_word(input logic [2:0] idx);
        logic [PAT_W-1:0] w;
        case (idx)
            3'd0:    w = 8'b0000_0000;
            3'd1:    w = 8'b1111_1111;
            3'd2:    w = 8'b0101_0101;
            3'd3:    w = 8'b0011_0011;
            3'd4:    w = 8'b0111_1111;
            3'd5:    w = 8'b1000_0000;
            3'd6:    w = 8'b0111_0111;
            default: w = 8'b1000_1000;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/prbs_rx_ref.sv
module prbs_rx_ref
    import prbs_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    load,
    input  rx_cfg_t cfg,
    input  logic    rx,
    input  logic    locked,
    output logic    mis
);

    logic [LFSR_W-1:0] sr;
    logic [PH_W-1:0]   ph;
    logic [PH_W-1:0]   pidx;
    logic [PAT_W-1:0]  pword;
    taps_t             tp;
    logic              zrun_hit;
    logic              prbs_exp;
    logic              pat_exp;
    logic              rx_eff;
    logic              exp_bit;

    always_comb begin
        tp       = poly_taps(cfg.sel[2:0]);
        zrun_hit = (cfg.sel == ZSUP_SEL) && (sr[ZRUN-1:0] == '0);
        prbs_exp = (sr[tp.tap_lo - 5'd1] ^ sr[tp.tap_hi - 5'd1]) | zrun_hit;
        pword    = pat_word(cfg.sel[2:0]);
        pidx     = PH_W'(PAT_W - 1) - ph;
        pat_exp  = pword[pidx];
        rx_eff   = cfg.sel[SEL_W-1] ? rx : (rx ^ cfg.inv);
        exp_bit  = cfg.sel[SEL_W-1] ? pat_exp : prbs_exp;
        mis      = rx_eff ^ exp_bit;
    end

    // hunting: load received bits / slip word phase; locked: free-run
    always_ff @(posedge clk) begin
        if (rst || load) begin
            sr <= '1;
            ph <= '0;
        end else if (en) begin
            sr <= {sr[LFSR_W-2:0], (locked ? prbs_exp : rx_eff)};
            if (locked || !mis) begin
                ph <= ph + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prbs_rx_win.sv
module prbs_rx_win #(
    parameter int DEPTH = 128,
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clear,
    input  logic push,
    output logic over,
    output logic aged
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] hist;
    logic [CW-1:0]    tally;
    logic [CW-1:0]    tally_nx;

    assign aged     = hist[DEPTH-1];
    assign tally_nx = tally + CW'(push) - CW'(aged);
    assign over     = tally_nx > CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist  <= '0;
            tally <= '0;
        end else if (en) begin
            hist  <= {hist[DEPTH-2:0], push};
            tally <= tally_nx;
        end
    end

endmodule

// File: rtl/prbs_rx_mon.sv
module prbs_rx_mon
    import prbs_rx_pkg::*;
#(
    parameter int WIN_LEN  = 128,
    parameter int LOSS_LIM = 25,
    parameter int PAT_LOCK = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rx_bit,
    input  logic             cfg_set,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_inv,
    output logic             sync_o,
    output logic             loss_o,
    output logic             err_o,
    output logic             slip_o
);

    rx_cfg_t          cfg;
    taps_t            tp;
    logic [CNT_W-1:0] run;
    logic [CNT_W-1:0] run_nx;
    logic [CNT_W-1:0] lock_len;
    logic             load;
    logic             drop;
    logic             mis;
    logic             over;
    logic             aged;

    assign load     = en & cfg_set;
    assign drop     = en & ~cfg_set & sync_o & over;
    assign tp       = poly_taps(cfg.sel[2:0]);
    assign lock_len = cfg.sel[SEL_W-1] ? CNT_W'(PAT_LOCK) : CNT_W'({tp.tap_hi, 1'b0});
    assign run_nx   = run + 1'b1;
    assign slip_o   = 1'b0;

    prbs_rx_ref u_ref (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .load   (load),
        .cfg    (cfg),
        .rx     (rx_bit),
        .locked (sync_o),
        .mis    (mis)
    );

    prbs_rx_win #(
        .DEPTH (WIN_LEN),
        .LIMIT (LOSS_LIM)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .clear (load | drop),
        .push  (mis & sync_o),
        .over  (over),
        .aged  (aged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            sync_o <= 1'b0;
            run    <= '0;
            loss_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            loss_o <= 1'b0;
            err_o  <= 1'b0;
            if (load) begin
                cfg    <= '{sel: cfg_sel, inv: cfg_inv};
                sync_o <= 1'b0;
                run    <= '0;
            end else if (en) begin
                if (sync_o) begin
                    if (over) begin
                        sync_o <= 1'b0;
                        loss_o <= 1'b1;
                        run    <= '0;
                    end else begin
                        err_o <= aged;
                    end
                end else if (mis) begin
                    run <= '0;
                end else if (run_nx == lock_len) begin
                    sync_o <= 1'b1;
                    run    <= '0;
                end else begin
                    run <= run_nx;
                end
            end
        end
    end

endmodule

// File: rtl/prbs_rx_mon_chk.sv
module prbs_rx_mon_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cfg_set,
    input logic sync_o,
    input logic loss_o,
    input logic err_o,
    input logic slip_o
);

    a_r7_loss_marks_fall: assert property (@(posedge clk) disable iff (rst)
        loss_o |-> (!sync_o && $past(sync_o)));

    a_r7_loss_single: assert property (@(posedge clk) disable iff (rst)
        loss_o |=> !loss_o);

    a_r9_err_needs_lock: assert property (@(posedge clk) disable iff (rst)
        err_o |-> sync_o);

    a_r12_load_clears: assert property (@(posedge clk) disable iff (rst)
        (en && cfg_set) |=> (!sync_o && !loss_o));

    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !rst) |=> (!loss_o && !err_o && $stable(sync_o)));

    a_r14_slip_low: assert property (@(posedge clk) disable iff (rst)
        !slip_o);

endmodule

bind prbs_rx_mon prbs_rx_mon_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cfg_set (cfg_set),
    .sync_o  (sync_o),
    .loss_o  (loss_o),
    .err_o   (err_o),
    .slip_o  (slip_o)
);

// File: tb/sim_prbs_rx_mon.sv
module sim_prbs_rx_mon;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       rx_bit = 1'b0;
    logic       cfg_set = 1'b0;
    logic [3:0] cfg_sel = 4'd0;
    logic       cfg_inv = 1'b0;
    logic       sync_o, loss_o, err_o, slip_o;

    int checks = 0;
    int errors = 0;
    int nloss = 0;
    int nerr = 0;

    logic [30:0] g;
    logic [2:0]  gph;

    always #10 clk = ~clk;

    prbs_rx_mon u0 (
        .clk(clk), .rst(rst), .en(en), .rx_bit(rx_bit),
        .cfg_set(cfg_set), .cfg_sel(cfg_sel), .cfg_inv(cfg_inv),
        .sync_o(sync_o), .loss_o(loss_o), .err_o(err_o), .slip_o(slip_o)
    );

    // fields: [6:3] selector, [2] stream inverted, [1] flag to monitor, [0] lock expected
    localparam int NV = 22;
    localparam logic [6:0] VEC [NV] = '{
        {4'd0, 1'b0, 1'b0, 1'b1}, {4'd1, 1'b0, 1'b0, 1'b1},
        {4'd2, 1'b0, 1'b0, 1'b1}, {4'd3, 1'b0, 1'b0, 1'b1},
        {4'd4, 1'b0, 1'b0, 1'b1}, {4'd5, 1'b0, 1'b0, 1'b1},
        {4'd6, 1'b0, 1'b0, 1'b1}, {4'd7, 1'b0, 1'b0, 1'b1},
        {4'd2, 1'b1, 1'b1, 1'b1}, {4'd5, 1'b1, 1'b1, 1'b1},
        {4'd0, 1'b1, 1'b0, 1'b0}, {4'd7, 1'b0, 1'b1, 1'b0},
        {4'd8, 1'b0, 1'b0, 1'b1}, {4'd9, 1'b0, 1'b0, 1'b1},
        {4'd10, 1'b0, 1'b0, 1'b1}, {4'd11, 1'b0, 1'b0, 1'b1},
        {4'd12, 1'b0, 1'b0, 1'b1}, {4'd13, 1'b0, 1'b0, 1'b1},
        {4'd14, 1'b0, 1'b0, 1'b1}, {4'd15, 1'b0, 1'b0, 1'b1},
        {4'd10, 1'b0, 1'b1, 1'b1}, {4'd14, 1'b0, 1'b1, 1'b1}
    };

    function automatic int tap_a(input logic [2:0] s);
        case (s)
            3'd0: return 5;   3'd1: return 9;   3'd2: return 14;  3'd3: return 17;
            3'd4: return 3;   3'd5: return 18;  3'd6: return 27;  default: return 28;
        endcase
    endfunction

    function automatic int tap_b(input logic [2:0] s);
        case (s)
            3'd0: return 9;   3'd1: return 11;  3'd2: return 15;  3'd3: return 20;
            3'd4: return 20;  3'd5: return 23;  3'd6: return 29;  default: return 31;
        endcase
    endfunction

    function automatic logic [7:0] word_of(input logic [2:0] s);
        case (s)
            3'd0: return 8'h00;  3'd1: return 8'hFF;  3'd2: return 8'h55;  3'd3: return 8'h33;
            3'd4: return 8'h7F;  3'd5: return 8'h80;  3'd6: return 8'h77;  default: return 8'h88;
        endcase
    endfunction

    task automatic gen_next(input logic [3:0] s, input logic iv, output logic b);
        logic [7:0] w;
        logic f;
        if (s[3]) begin
            w   = word_of(s[2:0]);
            b   = w[3'd7 - gph];
            gph = gph + 3'd1;
        end else begin
            f = g[tap_a(s[2:0]) - 1] ^ g[tap_b(s[2:0]) - 1];
            if (s == 4'd4 && g[13:0] == 14'd0) f = 1'b1;
            g = {g[29:0], f};
            b = f ^ iv;
        end
    endtask

    task automatic push(input logic b);
        rx_bit = b;
        @(posedge clk);
        #1;
        if (loss_o) nloss++;
        if (err_o) nerr++;
    endtask

    task automatic load_cfg(input logic [3:0] s, input logic iv);
        cfg_sel = s;
        cfg_inv = iv;
        cfg_set = 1'b1;
        push(1'b0);
        cfg_set = 1'b0;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic b;
        int lo;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 / R14 reset state
        chk("R1", "sync after reset", sync_o, 0);
        chk("R1", "loss after reset", loss_o, 0);
        chk("R1", "err after reset", err_o, 0);
        chk("R14", "slip after reset", slip_o, 0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            load_cfg(VEC[i][6:3], VEC[i][1]);
            g   = 31'h2B3C_4D5E ^ 31'(i * 977);
            gph = 3'(i);
            lo  = VEC[i][6] ? 20 : 2 * tap_b(VEC[i][5:3]);
            nloss = 0;
            for (int k = 0; k < lo - 1; k++) begin
                gen_next(VEC[i][6:3], VEC[i][2], b);
                push(b);
            end
            chk(VEC[i][6] ? "R5" : "R4", "lock before run complete", sync_o, 0);
            for (int k = lo - 1; k < 130; k++) begin
                gen_next(VEC[i][6:3], VEC[i][2], b);
                push(b);
            end
            chk(VEC[i][6] ? "R3" : (VEC[i][0] ? "R2" : "R6"), "lock after stream",
                sync_o, int'(VEC[i][0]));
            chk("R6", "loss during table entry", nloss, 0);
        end

        // R5 exact acquisition on all-ones word
        load_cfg(4'd9, 1'b0);
        repeat (19) push(1'b1);
        chk("R5", "lock at 19 bits", sync_o, 0);
        push(1'b1);
        chk("R5", "lock at 20 bits", sync_o, 1);

        // R9 one error reported 128 clocks later
        nerr = 0;
        push(1'b0);
        chk("R9", "no immediate report", err_o, 0);
        repeat (127) push(1'b1);
        chk("R9", "report not at 127", err_o, 0);
        push(1'b1);
        chk("R9", "report at 128", err_o, 1);
        push(1'b1);
        chk("R9", "report one clock", err_o, 0);

        // R12 selector change without strobe ignored
        nloss = 0;
        cfg_sel = 4'd8;
        repeat (30) push(1'b1);
        chk("R12", "lock kept without strobe", sync_o, 1);
        chk("R12", "no loss without strobe", nloss, 0);

        // R13 enable low freezes everything
        nerr = 0;
        en = 1'b0;
        cfg_set = 1'b1;
        rx_bit = 1'b0;
        repeat (40) begin @(posedge clk); #1; if (err_o || loss_o) nerr++; end
        cfg_set = 1'b0;
        chk("R13", "lock held with enable low", sync_o, 1);
        en = 1'b1;
        repeat (140) push(1'b1);
        chk("R13", "nothing recorded while idle", nerr, 0);
        chk("R13", "still locked", sync_o, 1);

        // R8 sliding window, 20 + 20 errors across 128 bits
        nerr = 0;
        nloss = 0;
        repeat (20) push(1'b0);
        repeat (108) push(1'b1);
        repeat (20) push(1'b0);
        repeat (140) push(1'b1);
        chk("R8", "no loss from aged errors", nloss, 0);
        chk("R9", "all errors reported", nerr, 40);

        // R7 limit then loss
        nloss = 0;
        repeat (25) push(1'b0);
        chk("R7", "lock at 25 errors", sync_o, 1);
        chk("R7", "no loss at 25", nloss, 0);
        nerr = 0;
        push(1'b0);
        chk("R7", "lock falls at 26", sync_o, 0);
        chk("R7", "loss pulse", loss_o, 1);
        push(1'b1);
        chk("R7", "loss one clock", loss_o, 0);
        // R10 burst never reported
        repeat (300) push(1'b1);
        chk("R10", "burst not reported", nerr, 0);
        chk("R10", "relocked", sync_o, 1);

        // R11 free-running register in sequence mode
        load_cfg(4'd0, 1'b0);
        g = 31'h0000_1A5;
        for (int k = 0; k < 60; k++) begin gen_next(4'd0, 1'b0, b); push(b); end
        chk("R11", "locked on sequence", sync_o, 1);
        nerr = 0;
        nloss = 0;
        gen_next(4'd0, 1'b0, b);
        push(~b);
        for (int k = 0; k < 140; k++) begin gen_next(4'd0, 1'b0, b); push(b); end
        chk("R11", "single report", nerr, 1);
        chk("R11", "no loss", nloss, 0);

        // R12 strobe clears lock with no loss pulse
        load_cfg(4'd0, 1'b0);
        chk("R12", "lock cleared by load", sync_o, 0);
        chk("R12", "no loss on load", loss_o, 0);
        chk("R14", "slip stays low", slip_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule